// File: doc/BRIEF.md
# Branch Target Buffer Next-PC Predictor

This block sits beside the fetch stage and turns the current fetch address into a guess for the next one. In the same cycle the fetch address is presented, it indexes a direct-mapped table and compares the whole stored branch address against the fetch address. If an entry is valid and matches exactly, the stored target is the next fetch address. Otherwise the prediction is the sequential address, fetch PC plus four. No decode information is needed, so the redirect happens before the instruction word is known.

The table is written only by resolved control transfers reported from the execute stage. A transfer that was taken, whether a branch or a jump, is written into the slot picked by its address, replacing whatever was there. A branch that resolved not-taken removes its own entry if one is present and touches nothing else. Never-taken branches therefore take no space.

Resolution reports arrive on a valid/ready channel. `upd_ready` is held high: the table accepts one report in every cycle and never applies back-pressure. A report is consumed in the cycle where `upd_valid` is high. The lookup path is a plain combinational control path with no handshake.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a taken update has been accepted.
- R2: On a miss, `pred_next_pc` equals `fetch_pc + 4` modulo 2^PC_W, and `pred_hit` is 0.
- R3: A hit requires the selected entry to be valid and its stored address to equal `fetch_pc` in all PC_W bits. An address that shares the index but differs in any other bit misses.
- R4: On a hit, `pred_hit` is 1 and `pred_next_pc` equals the stored target in the same cycle as `fetch_pc`, with no register on the lookup path.
- R5: An accepted report with `upd_taken`=1 writes a valid entry holding `upd_pc` and `upd_target` at the clock edge. Lookups of that address hit from the next cycle on.
- R6: A taken report whose index is already held by a different address replaces that entry. The old address then misses.
- R7: An accepted report with `upd_taken`=0 whose address matches a valid entry exactly clears that entry at the clock edge.
- R8: An accepted report with `upd_taken`=0 that does not match the entry at its index leaves the table unchanged.
- R9: The index is `pc[IDX_W+1:2]`, so the two byte-offset bits do not take part. Entries at different indices do not affect each other.
- R10: A lookup in the same cycle as an update of the same entry sees the contents from before that update.
- R11: `upd_ready` is 1 whenever reset is released, and a report is consumed in every cycle where `upd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved control transfer is reported |
| upd_ready | output | 1 | Table can accept a report (always 1 out of reset) |
| upd_pc | input | PC_W | Address of the resolved branch or jump |
| upd_target | input | PC_W | Resolved target address |
| upd_taken | input | 1 | 1 if the transfer was taken |

## Verification
The bench builds the block with PC_W=32 and IDX_W=3, so the table has eight slots. With so few slots, two addresses 32 bytes apart share a slot. This makes the exact-match, replacement and aliasing cases easy to reach. The top fetch address 0xFFFFFFFC is used to check the sequential wrap to zero. Same-cycle update and lookup of a single slot shows that the lookup reads the old contents.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned OFS_W      = 2;
endpackage

// File: rtl/btb_table.sv
module btb_table #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PC_W-1:0]  rd_pc,
  output logic [PC_W-1:0]  rd_tgt,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             wr_cur_valid,
  output logic [PC_W-1:0]  wr_cur_pc,
  input  logic             wr_alloc,
  input  logic             wr_inval,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [PC_W-1:0]  wr_tgt
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] ent_valid;
  logic [PC_W-1:0]  ent_pc  [DEPTH];
  logic [PC_W-1:0]  ent_tgt [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
    end else if (wr_alloc) begin
      ent_valid[wr_idx] <= 1'b1;
    end else if (wr_inval) begin
      ent_valid[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_alloc) begin
      ent_pc[wr_idx]  <= wr_pc;
      ent_tgt[wr_idx] <= wr_tgt;
    end
  end

  assign rd_valid     = ent_valid[rd_idx];
  assign rd_pc        = ent_pc[rd_idx];
  assign rd_tgt       = ent_tgt[rd_idx];
  assign wr_cur_valid = ent_valid[wr_idx];
  assign wr_cur_pc    = ent_pc[wr_idx];

  // R1: first cycle out of reset sees an empty table
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ent_valid == '0));

  // R5/R6: allocation leaves the written slot valid with the new address
  assert_alloc_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alloc |=> (ent_valid[$past(wr_idx)] && ent_pc[$past(wr_idx)] == $past(wr_pc)
                  && ent_tgt[$past(wr_idx)] == $past(wr_tgt)));

  // R7: invalidation empties the slot
  assert_inval_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inval && !wr_alloc) |=> !ent_valid[$past(wr_idx)]);

  // R8: no write request, no change in the valid bits
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_alloc && !wr_inval) |=> $stable(ent_valid));
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int unsigned PC_W = 32
) (
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            ent_valid,
  input  logic [PC_W-1:0] ent_pc,
  input  logic [PC_W-1:0] ent_tgt,
  output logic            hit,
  output logic [PC_W-1:0] next_pc
);
  import btb_pkg::*;

  logic [PC_W-1:0] seq_pc;

  always_comb begin
    seq_pc  = fetch_pc + PC_W'(INSN_BYTES);
    hit     = ent_valid && (ent_pc == fetch_pc);
    next_pc = hit ? ent_tgt : seq_pc;
  end
endmodule

// File: rtl/btb_update_ctrl.sv
module btb_update_ctrl #(
  parameter int unsigned PC_W = 32
) (
  input  logic            upd_valid,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            cur_valid,
  input  logic [PC_W-1:0] cur_pc,
  output logic            alloc,
  output logic            inval
);
  always_comb begin
    alloc = upd_valid && upd_taken;
    inval = upd_valid && !upd_taken && cur_valid && (cur_pc == upd_pc);
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken
);
  import btb_pkg::*;

  localparam int unsigned IDX_LO = OFS_W;
  localparam int unsigned IDX_HI = OFS_W + IDX_W - 1;

  logic [IDX_W-1:0] look_idx, upd_idx;
  logic             rd_valid, cur_valid, alloc, inval;
  logic [PC_W-1:0]  rd_pc, rd_tgt, cur_pc;

  assign look_idx  = fetch_pc[IDX_HI:IDX_LO];
  assign upd_idx   = upd_pc[IDX_HI:IDX_LO];
  assign upd_ready = 1'b1;

  btb_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_idx       (look_idx),
    .rd_valid     (rd_valid),
    .rd_pc        (rd_pc),
    .rd_tgt       (rd_tgt),
    .wr_idx       (upd_idx),
    .wr_cur_valid (cur_valid),
    .wr_cur_pc    (cur_pc),
    .wr_alloc     (alloc),
    .wr_inval     (inval),
    .wr_pc        (upd_pc),
    .wr_tgt       (upd_target)
  );

  btb_update_ctrl #(.PC_W(PC_W)) u_upd (
    .upd_valid (upd_valid && upd_ready),
    .upd_taken (upd_taken),
    .upd_pc    (upd_pc),
    .cur_valid (cur_valid),
    .cur_pc    (cur_pc),
    .alloc     (alloc),
    .inval     (inval)
  );

  btb_lookup #(.PC_W(PC_W)) u_look (
    .fetch_pc  (fetch_pc),
    .ent_valid (rd_valid),
    .ent_pc    (rd_pc),
    .ent_tgt   (rd_tgt),
    .hit       (pred_hit),
    .next_pc   (pred_next_pc)
  );

  // R5: a taken report makes its own address hit on the following cycle
  assert_taken_then_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !(fetch_pc == upd_pc)) |=>
      (fetch_pc != $past(upd_pc) || !$past(upd_valid) || pred_hit));

  // R11: report channel never stalls out of reset
  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> upd_ready);
endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;
  localparam int unsigned PC_W   = 32;
  localparam int unsigned IDX_W  = 3;
  localparam time         PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_hit;
  logic [PC_W-1:0] pred_next_pc;
  logic            upd_valid = 1'b0;
  logic            upd_ready;
  logic [PC_W-1:0] upd_pc = '0;
  logic [PC_W-1:0] upd_target = '0;
  logic            upd_taken = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_taken(upd_taken)
  );

  task automatic look(input logic [PC_W-1:0] pc, input logic exp_hit,
                      input logic [PC_W-1:0] exp_next, input string req);
    fetch_pc = pc;
    #1;
    n_chk++;
    if (pred_hit !== exp_hit || pred_next_pc !== exp_next) begin
      n_bad++;
      $display("FAIL %s pc=%h actual hit=%b next=%h expected hit=%b next=%h",
               req, pc, pred_hit, pred_next_pc, exp_hit, exp_next);
    end
  endtask

  task automatic report(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt,
                        input logic taken);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = taken;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();  // R1, R2, R11
    do_reset();
    for (int i = 0; i < 8; i++) look(32'h100 + 32'(i*4), 1'b0, 32'h104 + 32'(i*4), "R1");
    n_chk++;
    if (upd_ready !== 1'b1) begin
      n_bad++; $display("FAIL R11 actual ready=%b expected 1", upd_ready);
    end
  endtask

  task automatic t_wrap();  // R2
    look(32'hFFFF_FFFC, 1'b0, 32'h0, "R2");
    look(32'h0000_1230, 1'b0, 32'h0000_1234, "R2");
  endtask

  task automatic t_alloc();  // R4, R5
    report(32'h0000_0104, 32'h0000_2000, 1'b1);
    look(32'h0000_0104, 1'b1, 32'h0000_2000, "R4");
    look(32'h0000_0108, 1'b0, 32'h0000_010C, "R5");
  endtask

  task automatic t_alias();  // R3, R9: 0x124 shares index 1 with 0x104
    look(32'h0000_0124, 1'b0, 32'h0000_0128, "R3");
    look(32'h8000_0104, 1'b0, 32'h8000_0108, "R3");
    look(32'h0000_0105, 1'b0, 32'h0000_0109, "R3");
  endtask

  task automatic t_indep();  // R9
    report(32'h0000_0208, 32'h0000_3000, 1'b1);  // index 2
    look(32'h0000_0208, 1'b1, 32'h0000_3000, "R9");
    look(32'h0000_0104, 1'b1, 32'h0000_2000, "R9");
  endtask

  task automatic t_replace();  // R6
    report(32'h0000_0124, 32'h0000_4000, 1'b1);
    look(32'h0000_0124, 1'b1, 32'h0000_4000, "R6");
    look(32'h0000_0104, 1'b0, 32'h0000_0108, "R6");
  endtask

  task automatic t_nt_miss();  // R8
    report(32'h0000_0104, 32'h0000_9999, 1'b0);
    look(32'h0000_0124, 1'b1, 32'h0000_4000, "R8");
    report(32'h0000_020C, 32'h0000_9999, 1'b0);
    look(32'h0000_0208, 1'b1, 32'h0000_3000, "R8");
  endtask

  task automatic t_inval();  // R7
    report(32'h0000_0124, 32'h0000_4000, 1'b0);
    look(32'h0000_0124, 1'b0, 32'h0000_0128, "R7");
    look(32'h0000_0208, 1'b1, 32'h0000_3000, "R7");
  endtask

  task automatic t_same_cycle();  // R10
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_031C; upd_target = 32'h0000_5000; upd_taken = 1'b1;
    look(32'h0000_031C, 1'b0, 32'h0000_0320, "R10");
    @(negedge clk);
    upd_valid = 1'b0;
    look(32'h0000_031C, 1'b1, 32'h0000_5000, "R10");
    @(negedge clk);
    upd_valid = 1'b1; upd_taken = 1'b0;
    look(32'h0000_031C, 1'b1, 32'h0000_5000, "R10");
    @(negedge clk);
    upd_valid = 1'b0;
    look(32'h0000_031C, 1'b0, 32'h0000_0320, "R7");
  endtask

  task automatic t_reset_again();  // R1
    report(32'h0000_0110, 32'h0000_6000, 1'b1);
    do_reset();
    look(32'h0000_0110, 1'b0, 32'h0000_0114, "R1");
    look(32'h0000_0208, 1'b0, 32'h0000_020C, "R1");
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wrap();
    t_alloc();
    t_alias();
    t_indep();
    t_replace();
    t_nt_miss();
    t_inval();
    t_same_cycle();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule